// File: doc/BRIEF.md
# Debug Link Command CRC-8 Unit

This block keeps a running 8-bit cyclic redundancy check over every byte that crosses a single-wire debug link during one command. Bytes from the host and bytes sent back to it both go into the same accumulator. A command-start pulse loads the accumulator with all ones. Each valid byte is folded in within one clock, with all eight bit steps unrolled. The generator is x^8 + x^2 + x + 1, and each byte is consumed least significant bit first.

When the command ends, the block forms the trailer byte: the accumulated value, bit-reversed and then complemented. It presents this byte on `crc_out` with a one-cycle `crc_send` strobe. The strobe appears only if the trailer is enabled and the link has been initialized. Before initialization, for example during the first revision query, no trailer is produced, although bytes are still accumulated.

For received frames, `crc_match` reports whether the accumulator holds the fixed residue CFh. That is the value left after a message followed by its own correct trailer byte.

Top module: `crc8_link_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after, `crc_send` is 0, `crc_out` is 00h and `crc_match` is 0.
- R2: A `cmd_start` pulse with no byte loads the accumulator with FFh. A command with no bytes therefore ends with `crc_out` = 00h.
- R3: The trailer byte follows polynomial 07h (x^8+x^2+x+1), preset FFh, bits taken LSB first, and a final bit reversal then inversion. For the ASCII string "123456789" the trailer is 2Fh.
- R4: An `end_cmd` sampled while `crc_en` and `link_init` are both 1 raises `crc_send` for exactly the next cycle, with the trailer on `crc_out`. A byte that is valid in the same cycle as `end_cmd` is included in that trailer.
- R5: With `crc_en` = 0, `end_cmd` raises no `crc_send` and leaves `crc_out` unchanged.
- R6: With `link_init` = 0, `end_cmd` raises no `crc_send` and leaves `crc_out` unchanged.
- R7: Feeding a message followed by its trailer byte leaves the accumulator at residue CFh, so `crc_match` = 1 on the cycle after that byte.
- R8: A byte that is valid in the same cycle as `cmd_start` is folded onto the FFh preset as the first byte of the new command.
- R9: Cycles with `byte_valid` = 0 leave the accumulator unchanged, whatever `byte_data` holds.
- R10: `crc_out` holds its value on every cycle that does not follow a qualifying `end_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse marking the first cycle of a command; presets the accumulator |
| byte_valid | input | 1 | The link byte on `byte_data` is valid this cycle |
| byte_data | input | 8 | Link byte, received or transmitted |
| end_cmd | input | 1 | Pulse requesting the trailer byte |
| crc_en | input | 1 | Trailer enable control bit |
| link_init | input | 1 | The link has been initialized |
| crc_out | output | 8 | Trailer byte (reversed, inverted accumulator) |
| crc_send | output | 1 | One-cycle strobe: `crc_out` is fresh and should be sent |
| crc_match | output | 1 | The accumulator equals the CFh residue |

## Verification
The bench builds the unit with its default parameters. These are an 8-bit accumulator, 8-bit link bytes, polynomial 07h and residue CFh, and with them the known-answer string and the residue property can be checked against fixed constants. Expected trailers for the remaining stimulus come from a shift-left, non-reflected serial model in the bench, reversed at the end. This model is a different formulation from the reflected, unrolled datapath in the design. The 8-bit data width also puts the corner cases within reach: a command that starts and feeds a byte in the same cycle, and a command that ends and feeds a byte in the same cycle.

// File: rtl/crc8_link_pkg.sv
package crc8_link_pkg;

    localparam int          CRC_W_DEF   = 8;
    localparam int          DATA_W_DEF  = 8;
    localparam logic [7:0]  POLY_DEF    = 8'h07;
    localparam logic [7:0]  RESIDUE_DEF = 8'hCF;

    // One link event presented to the accumulator
    typedef struct packed {
        logic                  start;
        logic                  valid;
        logic [DATA_W_DEF-1:0] data;
    } link_evt_t;

    // Trailer request qualifiers
    typedef struct packed {
        logic finish;
        logic enable;
        logic ready;
    } emit_req_t;

    function automatic logic emit_allowed(input emit_req_t r);
        return r.finish && r.enable && r.ready;
    endfunction

endpackage

// File: rtl/crc8_bit_chain.sv
module crc8_bit_chain #(
    parameter int               CRC_W  = 8,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
        return r;
    endfunction

    // Reflected generator: LSB-first shifting in a right-shift register
    localparam logic [CRC_W-1:0] RPOLY = mirror(POLY);

    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = crc_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        logic fb;
        assign fb           = stage[i][0] ^ data_i[i];
        assign stage[i+1]   = (stage[i] >> 1) ^ (fb ? RPOLY : '0);
    end

    assign crc_o = stage[DATA_W];

endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
    import crc8_link_pkg::*;
#(
    parameter int               CRC_W  = 8,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  state_o,
    output logic [CRC_W-1:0]  next_o
);

    localparam logic [CRC_W-1:0] PRESET = '1;

    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] folded;

    // Command start presets before the same-cycle byte is folded in
    assign base = start_i ? PRESET : state_q;

    crc8_bit_chain #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_chain (
        .crc_i  (base),
        .data_i (data_i),
        .crc_o  (folded)
    );

    always_comb begin
        next_o = base;
        if (valid_i) next_o = folded;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PRESET;
        else     state_q <= next_o;
    end

    assign state_o = state_q;

endmodule

// File: rtl/crc8_emit.sv
module crc8_emit
    import crc8_link_pkg::*;
#(
    parameter int CRC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  emit_req_t        req_i,
    input  logic [CRC_W-1:0] next_i,
    output logic [CRC_W-1:0] out_o,
    output logic             send_o
);

    // Reflected register already holds the bit-reversed value; only invert
    logic [CRC_W-1:0] trailer;
    assign trailer = ~next_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o  <= '0;
            send_o <= 1'b0;
        end else begin
            send_o <= emit_allowed(req_i);
            if (emit_allowed(req_i)) out_o <= trailer;
        end
    end

endmodule

// File: rtl/crc8_link_unit.sv
module crc8_link_unit
    import crc8_link_pkg::*;
#(
    parameter int               CRC_W   = CRC_W_DEF,
    parameter int               DATA_W  = DATA_W_DEF,
    parameter logic [CRC_W-1:0] POLY    = POLY_DEF,
    parameter logic [CRC_W-1:0] RESIDUE = RESIDUE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              end_cmd,
    input  logic              crc_en,
    input  logic              link_init,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_send,
    output logic              crc_match
);

    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] state_nx;
    emit_req_t        req;
    logic             match_q;

    assign req.finish = end_cmd;
    assign req.enable = crc_en;
    assign req.ready  = link_init;

    crc8_accum #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_accum (
        .clk     (clk),
        .rst     (rst),
        .start_i (cmd_start),
        .valid_i (byte_valid),
        .data_i  (byte_data),
        .state_o (state_q),
        .next_o  (state_nx)
    );

    crc8_emit #(
        .CRC_W (CRC_W)
    ) u_emit (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .next_i (state_nx),
        .out_o  (crc_out),
        .send_o (crc_send)
    );

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= (state_nx == RESIDUE);
    end

    assign crc_match = match_q;

endmodule

// File: rtl/crc8_link_checker.sv
module crc8_link_checker #(
    parameter int CRC_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_start,
    input logic              byte_valid,
    input logic [DATA_W-1:0] byte_data,
    input logic              end_cmd,
    input logic              crc_en,
    input logic              link_init,
    input logic [CRC_W-1:0]  crc_out,
    input logic              crc_send,
    input logic              crc_match,
    input logic [CRC_W-1:0]  state
);

    // R1: reset clears the strobe and the match flag
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!crc_send && !crc_match && crc_out == '0));

    // R2: start without a byte leaves the preset value
    a_r2_preset: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !byte_valid) |=> (state == '1));

    // R4: qualified end of command raises the strobe
    a_r4_send: assert property (@(posedge clk) disable iff (rst)
        (end_cmd && crc_en && link_init) |=> crc_send);

    // R5 / R6: no strobe unless enabled and initialized
    a_r5_r6_no_send: assert property (@(posedge clk) disable iff (rst)
        !(end_cmd && crc_en && link_init) |=> !crc_send);

    // R9: idle cycles keep the accumulator
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd_start && !byte_valid) |=> $stable(state));

    // R10: trailer byte only moves with the strobe
    a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
        !crc_send |-> $stable(crc_out));

endmodule

bind crc8_link_unit crc8_link_checker #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .end_cmd    (end_cmd),
    .crc_en     (crc_en),
    .link_init  (link_init),
    .crc_out    (crc_out),
    .crc_send   (crc_send),
    .crc_match  (crc_match),
    .state      (state_q)
);

// File: tb/sim_crc8_link_unit.sv
`timescale 1ns/1ps
module sim_crc8_link_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_start, byte_valid, end_cmd, crc_en, link_init;
    logic [7:0] byte_data;
    logic [7:0] crc_out;
    logic       crc_send, crc_match;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;   // 125 MHz

    crc8_link_unit u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .end_cmd(end_cmd), .crc_en(crc_en),
        .link_init(link_init), .crc_out(crc_out), .crc_send(crc_send),
        .crc_match(crc_match)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = v[7-k];
        return r;
    endfunction

    // Shift-left serial model, LSB of each byte first; returns register
    function automatic logic [7:0] ref_reg(input int n, input logic [95:0] msg);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[7] ^ msg[8*i+b];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_trailer(input int n, input logic [95:0] msg);
        return ~rev8(ref_reg(n, msg));
    endfunction

    task automatic run_cmd(input int n, input logic [95:0] msg, input bit fuse_start,
                           input bit gaps, input bit end_last);
        if (!fuse_start) begin
            @(negedge clk); cmd_start = 1;
            @(negedge clk); cmd_start = 0;
        end else begin
            @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            cmd_start  = fuse_start && (i == 0);
            byte_valid = 1;
            byte_data  = msg[8*i +: 8];
            end_cmd    = end_last && (i == n-1);
            @(negedge clk);
            cmd_start = 0; byte_valid = 0; end_cmd = 0;
            if (gaps) begin
                byte_data = 8'hA5 ^ 8'(i);
                @(negedge clk);
                byte_data = ~byte_data;
                @(negedge clk);
            end
        end
        if (!end_last) begin
            end_cmd = 1;
            @(negedge clk);
            end_cmd = 0;
        end
    endtask

    // {len[39:36], pad[35:34], en[33], init[32], bytes[31:0]}
    localparam logic [39:0] VEC [6] = '{
        {4'd1, 2'b00, 1'b1, 1'b1, 32'h0000_0000},
        {4'd4, 2'b00, 1'b1, 1'b1, 32'hDEAD_BEEF},
        {4'd2, 2'b00, 1'b0, 1'b1, 32'h0000_1234},
        {4'd3, 2'b00, 1'b1, 1'b0, 32'h00AB_CDEF},
        {4'd4, 2'b00, 1'b1, 1'b1, 32'hFFFF_FFFF},
        {4'd1, 2'b00, 1'b1, 1'b1, 32'h0000_0080}
    };

    initial begin
        logic [7:0] last_out;
        logic [7:0] t;
        rst = 1; cmd_start = 0; byte_valid = 0; byte_data = 0;
        end_cmd = 0; crc_en = 1; link_init = 1;
        repeat (3) @(negedge clk);
        check("R1 send", {31'd0, crc_send}, 32'd0);
        check("R1 out", {24'd0, crc_out}, 32'd0);
        check("R1 match", {31'd0, crc_match}, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R1 send after release", {31'd0, crc_send}, 32'd0);

        // R2: empty command
        run_cmd(0, '0, 0, 0, 0);
        check("R2 empty send", {31'd0, crc_send}, 32'd1);
        check("R2 empty trailer", {24'd0, crc_out}, 32'h00);

        // R3: known answer
        run_cmd(9, {24'd0, 72'h39_38_37_36_35_34_33_32_31}, 0, 0, 0);
        check("R3 known answer", {24'd0, crc_out}, 32'h2F);
        check("R3 model agrees", {24'd0, crc_out},
              {24'd0, ref_trailer(9, {24'd0, 72'h39_38_37_36_35_34_33_32_31})});
        last_out = crc_out;

        // R4/R5/R6 table walk
        foreach (VEC[v]) begin
            crc_en    = VEC[v][33];
            link_init = VEC[v][32];
            run_cmd(int'(VEC[v][39:36]), {64'd0, VEC[v][31:0]}, 0, 0, 0);
            if (crc_en && link_init) begin
                last_out = ref_trailer(int'(VEC[v][39:36]), {64'd0, VEC[v][31:0]});
                check("R4 table send", {31'd0, crc_send}, 32'd1);
            end else begin
                check(crc_en ? "R6 table no send" : "R5 table no send",
                      {31'd0, crc_send}, 32'd0);
            end
            check(crc_en && link_init ? "R4 table trailer" : "R5/R6 table hold",
                  {24'd0, crc_out}, {24'd0, last_out});
        end
        crc_en = 1; link_init = 1;

        // R10: idle cycles keep the trailer and drop the strobe
        @(negedge clk);
        check("R10 strobe one cycle", {31'd0, crc_send}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10 out held", {24'd0, crc_out}, {24'd0, last_out});

        // R4: byte in the same cycle as end_cmd is included
        run_cmd(2, {80'd0, 16'h5A_C3}, 0, 0, 1);
        check("R4 end-cycle byte", {24'd0, crc_out}, {24'd0, ref_trailer(2, {80'd0, 16'h5A_C3})});

        // R7: residue after message plus its trailer
        t = ref_trailer(3, {72'd0, 24'h77_10_02});
        run_cmd(4, {64'd0, t, 24'h77_10_02}, 0, 0, 1);
        check("R7 residue match", {31'd0, crc_match}, 32'd1);
        run_cmd(4, {64'd0, t ^ 8'h01, 24'h77_10_02}, 0, 0, 1);
        check("R7 corrupted no match", {31'd0, crc_match}, 32'd0);

        // R8: start fused with first byte
        run_cmd(3, {72'd0, 24'h44_33_E1}, 1, 0, 0);
        check("R8 fused start", {24'd0, crc_out}, {24'd0, ref_trailer(3, {72'd0, 24'h44_33_E1})});

        // R9: idle gaps with changing data
        run_cmd(3, {72'd0, 24'h9C_06_F0}, 0, 1, 0);
        check("R9 gaps ignored", {24'd0, crc_out}, {24'd0, ref_trailer(3, {72'd0, 24'h9C_06_F0})});

        // R6: before initialization, bytes still accumulate but no trailer
        link_init = 0;
        last_out  = crc_out;
        run_cmd(1, {88'd0, 8'h00}, 0, 0, 0);
        check("R6 no send uninit", {31'd0, crc_send}, 32'd0);
        check("R6 out held uninit", {24'd0, crc_out}, {24'd0, last_out});
        link_init = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule